// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 interface. It takes the memory through its mandatory power-up steps. Once power is reported good, it holds the memory reset pin low for a programmed time and keeps clock enable low through the release of reset. It then waits out the post-reset interval and a clock-stabilization interval. After that it places one NOP on the command bus and raises clock enable. Clock enable stays high for a final hold that covers DLL lock and ZQ initialization, and then the ready flag is raised.

Every interval is supplied as a cycle count on an input port. The integrator converts each time floor into clock cycles, rounding up. The clock-stable wait is the larger of a programmed floor and a fixed minimum cycle count, `CLK_MIN_CYC`. If power-good drops at any point, the sequencer returns to its reset-asserted state and the sequence starts again.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `mem_reset_n`=0, `mem_cke`=0, the bus in deselect (`mem_cs_n`, `mem_ras_n`, `mem_cas_n`, `mem_we_n` all 1) and `init_done`=0, whatever `pwr_good` is.
- R2: `mem_reset_n` stays low for exactly max(`cyc_reset_hold`,1) + max(`cyc_cke_pre`,1) cycles. The count starts with the first cycle in which `pwr_good` is high.
- R3: `mem_cke` is low in every cycle where `mem_reset_n` is low.
- R4: After `mem_reset_n` rises, the bus shows deselect with `mem_cke` low for exactly max(`cyc_post_reset`,1) + W cycles, where W is the clock-stable wait from R5.
- R5: W equals the larger of `cyc_clk_floor` and the parameter `CLK_MIN_CYC` (default 5).
- R6: Exactly one NOP cycle (`mem_cs_n`=0, `mem_ras_n`=`mem_cas_n`=`mem_we_n`=1) with `mem_cke` low comes directly before the cycle in which `mem_cke` rises.
- R7: Once `mem_cke` rises it stays high while `pwr_good` holds. `init_done` rises after exactly max(`cyc_final_hold`,1) cycles of `mem_cke` high.
- R8: While `init_done` is high, `mem_cke` and `mem_reset_n` are high and the bus carries NOP. `init_done` stays high as long as `pwr_good` holds.
- R9: When `pwr_good` is low at a clock edge, the next cycle shows the R1 output state with `init_done` cleared. The sequence restarts from R2 when `pwr_good` returns.
- R10: A programmed count of zero behaves as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all intervals count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supplies stable; low restarts the sequence |
| cyc_reset_hold | input | CNT_W | Reset-low hold, cycles |
| cyc_cke_pre | input | CNT_W | Clock enable low before reset release, cycles |
| cyc_post_reset | input | CNT_W | Wait after reset release, cycles |
| cyc_clk_floor | input | CNT_W | Clock-stable time floor, cycles |
| cyc_final_hold | input | CNT_W | DLL lock and ZQ init hold with clock enable high, cycles |
| mem_reset_n | output | 1 | Memory reset pin, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| init_done | output | 1 | Initialization sequence complete |

## Verification
All outputs decode directly from the state register. A change of `pwr_good` or `rst_n` at an edge therefore appears in the very next cycle. Each phase length appears as a run of identical output cycles, and its length is the programmed count, or one for a zero. The bench samples on the falling edge and measures each run by counting samples from the first sample after `pwr_good` is raised. It compares each length with arithmetic values worked out from the counts. Power-loss checks fall one sample after the drop, at every offset from the first cycle through the done state.

// File: rtl/ddr3_pwrup_pkg.sv
// Shared types for the DDR3 power-up sequencer.
// Assumes command pins are active low in the order cs, ras, cas, we.
package ddr3_pwrup_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HOLD,
        ST_CKE_LOW_PRE,
        ST_POST_RESET_WAIT,
        ST_CLK_STABLE,
        ST_NOP_ISSUE,
        ST_CKE_HIGH_HOLD,
        ST_DONE
    } init_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_NOP      = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam mem_cmd_t CMD_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/ddr3_pwrup_timer.sv
// Interval down-counter shared by all sequencer phases.
// A load sets the remaining count. 'expired' is high in the last cycle of
// an interval, so a loaded value N gives max(N,1) cycles.
// Assumes the owner asserts load during reset; the counter has no reset of its own.
module ddr3_pwrup_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remaining;

    // Purpose: load a new interval, or count down toward zero.
    always_ff @(posedge clk) begin
        if (load) begin
            remaining <= load_val;
        end else if (remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    // Purpose: flag the final cycle (remaining count 0 or 1).
    assign expired = (remaining[CNT_W-1:1] == '0);

endmodule

// File: rtl/ddr3_pwrup_fsm.sv
// Phase controller: steps through the power-up phases in fixed order and
// selects the length of each new phase for the shared timer.
// Assumes the cycle-count inputs stay stable while pwr_good is high.
module ddr3_pwrup_fsm
    import ddr3_pwrup_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int CLK_MIN_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic [CNT_W-1:0] cyc_reset_hold,
    input  logic [CNT_W-1:0] cyc_cke_pre,
    input  logic [CNT_W-1:0] cyc_post_reset,
    input  logic [CNT_W-1:0] cyc_clk_floor,
    input  logic [CNT_W-1:0] cyc_final_hold,
    input  logic             expired,
    output init_state_t      state,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val
);
    localparam logic [CNT_W-1:0] CLK_MIN = CNT_W'(CLK_MIN_CYC);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    init_state_t state_q, state_nxt, state_eff;
    logic [CNT_W-1:0] clk_wait;

    // Purpose: clock-stable wait is the larger of floor and fixed minimum.
    assign clk_wait = (cyc_clk_floor > CLK_MIN) ? cyc_clk_floor : CLK_MIN;

    // Purpose: advance one phase when the current interval runs out.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RESET_HOLD:      if (expired) state_nxt = ST_CKE_LOW_PRE;
            ST_CKE_LOW_PRE:     if (expired) state_nxt = ST_POST_RESET_WAIT;
            ST_POST_RESET_WAIT: if (expired) state_nxt = ST_CLK_STABLE;
            ST_CLK_STABLE:      if (expired) state_nxt = ST_NOP_ISSUE;
            ST_NOP_ISSUE:       state_nxt = ST_CKE_HIGH_HOLD;
            ST_CKE_HIGH_HOLD:   if (expired) state_nxt = ST_DONE;
            ST_DONE:            state_nxt = ST_DONE;
            default:            state_nxt = ST_RESET_HOLD;
        endcase
        if (!pwr_good) state_nxt = ST_RESET_HOLD;
    end

    // Purpose: the state actually entered at the next edge, with reset applied.
    assign state_eff  = rst_n ? state_nxt : ST_RESET_HOLD;
    assign timer_load = !rst_n || !pwr_good || (state_eff != state_q);

    // Purpose: pick the interval length of the phase being entered.
    always_comb begin
        unique case (state_eff)
            ST_RESET_HOLD:      timer_val = cyc_reset_hold;
            ST_CKE_LOW_PRE:     timer_val = cyc_cke_pre;
            ST_POST_RESET_WAIT: timer_val = cyc_post_reset;
            ST_CLK_STABLE:      timer_val = clk_wait;
            ST_NOP_ISSUE:       timer_val = ONE;
            ST_CKE_HIGH_HOLD:   timer_val = cyc_final_hold;
            default:            timer_val = ONE;
        endcase
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET_HOLD;
        else        state_q <= state_nxt;
    end

    assign state = state_q;

endmodule

// File: rtl/ddr3_pwrup_drive.sv
// Pin driver: decodes the phase register into the memory pin levels.
// Purely combinational from a register, so each phase shows at the pins
// in the same cycle it starts.
module ddr3_pwrup_drive
    import ddr3_pwrup_pkg::*;
(
    input  init_state_t state,
    output logic        mem_reset_n,
    output logic        mem_cke,
    output mem_cmd_t    mem_cmd,
    output logic        init_done
);
    // Purpose: map each phase to reset, clock enable, command and ready levels.
    always_comb begin
        mem_reset_n = 1'b1;
        mem_cke     = 1'b0;
        mem_cmd     = CMD_DESELECT;
        init_done   = 1'b0;
        unique case (state)
            ST_RESET_HOLD, ST_CKE_LOW_PRE: mem_reset_n = 1'b0;
            ST_POST_RESET_WAIT, ST_CLK_STABLE: ;
            ST_NOP_ISSUE: mem_cmd = CMD_NOP;
            ST_CKE_HIGH_HOLD: begin
                mem_cke = 1'b1;
                mem_cmd = CMD_NOP;
            end
            ST_DONE: begin
                mem_cke   = 1'b1;
                mem_cmd   = CMD_NOP;
                init_done = 1'b1;
            end
            default: mem_reset_n = 1'b0;
        endcase
    end

endmodule

// File: rtl/ddr3_pwrup_seq.sv
// DDR3 power-up initialization sequencer, top level.
// Connects the phase controller, the shared interval timer and the pin driver.
// Assumes pwr_good is already synchronous to clk and CNT_W >= 2.
module ddr3_pwrup_seq
    import ddr3_pwrup_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int CLK_MIN_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic [CNT_W-1:0] cyc_reset_hold,
    input  logic [CNT_W-1:0] cyc_cke_pre,
    input  logic [CNT_W-1:0] cyc_post_reset,
    input  logic [CNT_W-1:0] cyc_clk_floor,
    input  logic [CNT_W-1:0] cyc_final_hold,
    output logic             mem_reset_n,
    output logic             mem_cke,
    output logic             mem_cs_n,
    output logic             mem_ras_n,
    output logic             mem_cas_n,
    output logic             mem_we_n,
    output logic             init_done
);
    init_state_t      state;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             expired;
    mem_cmd_t         cmd;

    ddr3_pwrup_fsm #(.CNT_W(CNT_W), .CLK_MIN_CYC(CLK_MIN_CYC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_good       (pwr_good),
        .cyc_reset_hold (cyc_reset_hold),
        .cyc_cke_pre    (cyc_cke_pre),
        .cyc_post_reset (cyc_post_reset),
        .cyc_clk_floor  (cyc_clk_floor),
        .cyc_final_hold (cyc_final_hold),
        .expired        (expired),
        .state          (state),
        .timer_load     (timer_load),
        .timer_val      (timer_val)
    );

    ddr3_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (expired)
    );

    ddr3_pwrup_drive u_drive (
        .state       (state),
        .mem_reset_n (mem_reset_n),
        .mem_cke     (mem_cke),
        .mem_cmd     (cmd),
        .init_done   (init_done)
    );

    // Purpose: split the command struct onto the individual pins.
    assign mem_cs_n  = cmd.cs_n;
    assign mem_ras_n = cmd.ras_n;
    assign mem_cas_n = cmd.cas_n;
    assign mem_we_n  = cmd.we_n;

endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
// Protocol checker for the power-up sequencer, attached through bind.
// Observes only the top-level ports.
module ddr3_pwrup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic mem_reset_n,
    input logic mem_cke,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic init_done
);
    // R1: reset forces the safe pin state in the next cycle
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!mem_reset_n && !mem_cke && mem_cs_n && !init_done));

    // R3: clock enable never high while memory reset is asserted
    a_r3_cke_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_reset_n |-> !mem_cke);

    // R6: the cycle before clock enable rises carries a NOP with reset released
    a_r6_nop_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cke) |-> ($past(mem_reset_n) && !$past(mem_cs_n) && $past(mem_ras_n)
                            && $past(mem_cas_n) && $past(mem_we_n)));

    // R7: clock enable held high while power stays good
    a_r7_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cke && pwr_good) |=> mem_cke);

    // R8: ready implies released reset, high clock enable and NOP on the bus
    a_r8_done_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (mem_cke && mem_reset_n && !mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n));

    // R8: ready is sticky while power stays good
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && pwr_good) |=> init_done);

    // R9: power loss returns to the reset state in the next cycle
    a_r9_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!mem_reset_n && !mem_cke && mem_cs_n && !init_done));

endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .mem_reset_n (mem_reset_n),
    .mem_cke     (mem_cke),
    .mem_cs_n    (mem_cs_n),
    .mem_ras_n   (mem_ras_n),
    .mem_cas_n   (mem_cas_n),
    .mem_we_n    (mem_we_n),
    .init_done   (init_done)
);

// File: tb/ddr3_pwrup_seq_test.sv
// Self-checking bench: sweeps small interval counts, measures every phase
// on falling-edge samples and checks power-loss behaviour at each offset.
module ddr3_pwrup_seq_test;
    localparam int CNT_W   = 20;
    localparam int CLK_MIN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic [CNT_W-1:0] cyc_reset_hold = '0, cyc_cke_pre = '0, cyc_post_reset = '0;
    logic [CNT_W-1:0] cyc_clk_floor = '0, cyc_final_hold = '0;
    logic mem_reset_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;

    int checks = 0;
    int fails  = 0;

    ddr3_pwrup_seq #(.CNT_W(CNT_W), .CLK_MIN_CYC(CLK_MIN)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .cyc_reset_hold(cyc_reset_hold), .cyc_cke_pre(cyc_cke_pre),
        .cyc_post_reset(cyc_post_reset), .cyc_clk_floor(cyc_clk_floor),
        .cyc_final_hold(cyc_final_hold),
        .mem_reset_n(mem_reset_n), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .init_done(init_done)
    );

    always #4 clk = ~clk;

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int cmd_now();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset/power-off pin state: reset 0, cke 0, deselect (15), done 0 -> packed 0_0_1111_0
    task automatic chk_off(input string req);
        chk_eq(req, {mem_reset_n, mem_cke, cmd_now(), init_done}, 6'b001111 << 1);
    endtask

    task automatic set_cfg(input int h, input int p, input int w, input int fl, input int f);
        cyc_reset_hold = CNT_W'(h);
        cyc_cke_pre    = CNT_W'(p);
        cyc_post_reset = CNT_W'(w);
        cyc_clk_floor  = CNT_W'(fl);
        cyc_final_hold = CNT_W'(f);
    endtask

    // One full sequence with phase lengths measured against the requirements.
    task automatic run_seq(input int h, input int p, input int w, input int fl, input int f,
                           input string note);
        int n, bad;
        int exp_rst = mx1(h) + mx1(p);
        int exp_des = mx1(w) + ((fl > CLK_MIN) ? fl : CLK_MIN);
        int exp_hi  = mx1(f);
        set_cfg(h, p, w, fl, f);
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        chk_off({"R9 held off", note});
        pwr_good = 1'b1;
        n = 0; bad = 0;
        while (!mem_reset_n && n < 1000) begin
            if (mem_cke) bad++;
            n++;
            @(negedge clk);
        end
        chk_eq({"R2 reset-low length", note}, n, exp_rst);
        chk_eq({"R3 cke high during reset", note}, bad, 0);
        n = 0;
        while (mem_reset_n && !mem_cke && cmd_now() == 15 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk_eq({"R4 R5 deselect length", note}, n, exp_des);
        chk_eq({"R6 nop cycle cmd", note}, cmd_now(), 7);
        chk_eq({"R6 nop cycle cke", note}, int'(mem_cke), 0);
        @(negedge clk);
        n = 0; bad = 0;
        while (mem_cke && !init_done && n < 1000) begin
            if (cmd_now() != 7) bad++;
            n++;
            @(negedge clk);
        end
        chk_eq({"R7 cke-high hold length", note}, n, exp_hi);
        chk_eq({"R6 nop during hold", note}, bad, 0);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            if (!(init_done && mem_cke && mem_reset_n && cmd_now() == 7)) bad++;
            @(negedge clk);
        end
        chk_eq({"R8 done state held", note}, bad, 0);
    endtask

    // Power-good drop k samples after the rise of pwr_good.
    task automatic abort_at(input int k);
        set_cfg(2, 2, 2, 6, 3);   // done reached at sample 16
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        pwr_good = 1'b1;
        repeat (k) @(negedge clk);
        chk_eq($sformatf("R8 done at offset %0d", k), int'(init_done), (k >= 16) ? 1 : 0);
        pwr_good = 1'b0;
        @(negedge clk);
        chk_off($sformatf("R9 power loss at offset %0d", k));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        // R1: reset dominates a high pwr_good
        repeat (2) @(negedge clk);
        chk_off("R1 reset state");
        rst_n = 1'b1;
        pwr_good = 1'b0;
        @(negedge clk);

        for (int h = 0; h < 4; h++) run_seq(h, 1, 2, 3, 2, "");
        for (int fl = 0; fl < 9; fl++) run_seq(1, 1, 1, fl, 1, " floor sweep R5");
        for (int p = 0; p < 3; p++)
            for (int w = 0; w < 3; w++) run_seq(2, p, w, 6, 1, "");
        for (int f = 0; f < 4; f++) run_seq(1, 2, 1, 4, f, "");
        run_seq(0, 0, 0, 0, 0, " R10 all zero");
        run_seq(3, 3, 3, 7, 3, "");

        for (int k = 0; k < 20; k++) abort_at(k);

        // R1: reset while done returns to the safe state
        run_seq(1, 1, 1, 1, 1, " before reset");
        rst_n = 1'b0;
        @(negedge clk);
        chk_off("R1 reset from done");
        rst_n = 1'b1;
        run_seq(2, 1, 1, 2, 2, " after reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule